// File: doc/BRIEF.md
# Watermark-Gated Interrupt Controller

This block gathers interrupt causes from a network device into a sticky status register and filters them through a mask. It drives one interrupt request line toward a processor. Software reaches the block through a small register port with four registers: status, mask, command and delay. It can read the status, which clears it. It can also clear chosen status bits by writing ones to them, change the mask, raise a software cause, or reset the whole block through the command register.

Two causes act as one-shot events. The receive high-watermark cause is delivered only after the device has reported that its receive queue ran empty. The transmit low-watermark cause is delivered only after the device has reported that its transmit queue was full. Each report arms its cause for a single delivery. Any other post of the same cause sets its status bit but does not raise the line.

A delivery raises the line after a programmable coalescing delay. If the delivered set contains a cause of the no-delay class, or if the delay is zero, the line rises on the next clock edge instead. The line falls as soon as no unmasked status bit remains.

Top module: `wm_irq_ctrl`

## Requirements
- R1: A cause pulse on `cause_i` sets the matching status bit on the next edge, and the bit stays set until it is cleared. The status register is read at address 0 and holds, in bits [7:0]: bit 0 Soft, bit 1 RxHigh, bit 2 RxPacket, bit 3 TxLow, bits 4-7 further device causes.
- R2: A read of address 0 returns the current status and clears it on the same edge. A cause posted in that same cycle survives the clear.
- R3: A write to address 0 clears exactly those status bits that are set in the write data. All other bits are kept.
- R4: After reset the mask (address 1, bits [7:0], read/write) is 0x0F, so Soft, RxHigh, RxPacket and TxLow are enabled. The status is 0 and the delay register (address 3) is `RESET_DELAY`.
- R5: RxHigh (bit 1) is delivered only if an `rx_empty_i` pulse arrived since its last delivery. Delivering it uses up that arming. When it is not armed, it is left out of the set that can raise the line.
- R6: TxLow (bit 3) is delivered only if a `tx_full_i` pulse arrived since its last delivery, with the same single-use arming.
- R7: When a post leaves a cause of the no-delay class (default: Soft, bit 0) in the delivered set, `irq_o` rises on the next edge.
- R8: Any other delivery raises `irq_o` exactly N edges after the posting edge, where N is the delay register. A further post while the countdown runs does not restart it.
- R9: `irq_o` falls, and any countdown in progress is dropped, on the edge after which status AND mask is zero. This can follow a read, a clearing write or a mask write.
- R10: A command write (address 2) with bit 0 set posts the Soft cause. A command write with bit 1 set returns all state to its reset values, and that reset takes priority over bit 0.
- R11: When the delay register is 0, every delivery raises `irq_o` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cause_i | input | 8 | One-cycle cause pulses, one bit per cause |
| rx_empty_i | input | 1 | Pulse: receive queue ran empty (arms RxHigh) |
| tx_full_i | input | 1 | Pulse: transmit queue was full (arms TxLow) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register select: 0 status, 1 mask, 2 command, 3 delay |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for the selected register, combinational |
| irq_o | output | 1 | Interrupt request toward the processor |

## Verification
The assertions run on every cycle. They check that a posted cause lands in status, that a read or a clearing write leaves the expected status on the following edge, and that a watermark delivery uses up its arming. They also check that a no-delay delivery raises the line at once, that a running countdown only ever counts down, and that the line is never high without an unmasked status bit. Other properties need a scenario to show them. These are the exact edge on which a delayed line rises, the fact that an unarmed watermark cause never raises the line, the survival of a cause posted during a read, and the return of mask and delay to their reset values after a command reset. The bench's reference model and its directed register reads cover these.

// File: rtl/wmic_pkg.sv
package wmic_pkg;

    localparam int CAUSE_W  = 8;

    // cause bit positions (software decodes these from the status register)
    localparam int C_SOFT   = 0;
    localparam int C_RXHIGH = 1;
    localparam int C_RXPKT  = 2;
    localparam int C_TXLOW  = 3;

    localparam int CMD_SOFT_BIT  = 0;
    localparam int CMD_RESET_BIT = 1;

    typedef logic [CAUSE_W-1:0] cause_t;

    localparam cause_t MASK_AT_RESET =
        cause_t'((1 << C_SOFT) | (1 << C_RXHIGH) | (1 << C_RXPKT) | (1 << C_TXLOW));

    typedef enum logic [1:0] {
        RA_STATUS = 2'd0,
        RA_MASK   = 2'd1,
        RA_CMD    = 2'd2,
        RA_DELAY  = 2'd3
    } reg_addr_e;

    // outcome of evaluating one posting cycle
    typedef struct packed {
        logic any;     // something was delivered
        logic urgent;  // delivered set holds a no-delay cause
    } deliver_t;

    // remove watermark causes whose arming is absent
    function automatic cause_t gate_watermarks(cause_t eff, logic rx_arm, logic tx_arm);
        cause_t g;
        g = eff;
        if (!rx_arm) g[C_RXHIGH] = 1'b0;
        if (!tx_arm) g[C_TXLOW]  = 1'b0;
        return g;
    endfunction

endpackage

// File: rtl/wmic_cause_regs.sv
module wmic_cause_regs
    import wmic_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int DELAY_W     = 16,
    parameter int RESET_DELAY = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  cause_t            cause_in,
    output cause_t            status_q,
    output cause_t            mask_q,
    output logic [DELAY_W-1:0] delay_q,
    output cause_t            status_next,
    output cause_t            mask_next,
    output logic              post_any,
    output logic [DATA_W-1:0] rdata
);

    logic   soft_post;
    cause_t posts;

    assign soft_post = wr && (addr == RA_CMD) && wdata[CMD_SOFT_BIT];
    assign posts     = cause_in | (cause_t'(soft_post) << C_SOFT);
    assign post_any  = |posts;

    always_comb begin
        status_next = status_q;
        if (rd && addr == RA_STATUS) status_next = '0;
        if (wr && addr == RA_STATUS) status_next = status_next & ~wdata[CAUSE_W-1:0];
        status_next = status_next | posts;
        mask_next   = (wr && addr == RA_MASK) ? wdata[CAUSE_W-1:0] : mask_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            mask_q   <= MASK_AT_RESET;
            delay_q  <= DELAY_W'(RESET_DELAY);
        end else begin
            status_q <= status_next;
            mask_q   <= mask_next;
            if (wr && addr == RA_DELAY) delay_q <= wdata[DELAY_W-1:0];
        end
    end

    always_comb begin
        case (addr)
            RA_STATUS: rdata = DATA_W'(status_q);
            RA_MASK:   rdata = DATA_W'(mask_q);
            RA_DELAY:  rdata = DATA_W'(delay_q);
            default:   rdata = '0;
        endcase
    end

    AST_POST_STICKS: assert property (@(posedge clk) disable iff (rst)
        (cause_in != '0 && !rd && !wr) |=> ((status_q & $past(cause_in)) == $past(cause_in))); // R1

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == RA_STATUS && cause_in == '0 && !wr) |=> (status_q == '0)); // R2

    AST_W1C_EXACT: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == RA_STATUS && !rd && cause_in == '0)
        |=> (status_q == ($past(status_q) & ~$past(wdata[CAUSE_W-1:0])))); // R3

endmodule

// File: rtl/wmic_wm_gate.sv
module wmic_wm_gate
    import wmic_pkg::*;
#(
    parameter cause_t NODELAY_SET = cause_t'(1 << C_SOFT)
) (
    input  logic     clk,
    input  logic     rst,
    input  cause_t   status_next,
    input  cause_t   mask_next,
    input  logic     post_any,
    input  logic     rx_empty_evt,
    input  logic     tx_full_evt,
    output deliver_t dlv
);

    logic   rx_arm_q, tx_arm_q;
    logic   rx_take, tx_take;
    cause_t eff;

    assign eff        = gate_watermarks(status_next & mask_next, rx_arm_q, tx_arm_q);
    assign rx_take    = post_any && eff[C_RXHIGH];
    assign tx_take    = post_any && eff[C_TXLOW];
    assign dlv.any    = post_any && (eff != '0);
    assign dlv.urgent = post_any && ((eff & NODELAY_SET) != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_arm_q <= 1'b0;
            tx_arm_q <= 1'b0;
        end else begin
            rx_arm_q <= (rx_arm_q && !rx_take) || rx_empty_evt;
            tx_arm_q <= (tx_arm_q && !tx_take) || tx_full_evt;
        end
    end

    AST_RX_ARM_USED: assert property (@(posedge clk) disable iff (rst)
        (rx_arm_q && post_any && (status_next[C_RXHIGH] && mask_next[C_RXHIGH]) && !rx_empty_evt)
        |=> !rx_arm_q); // R5

    AST_TX_ARM_USED: assert property (@(posedge clk) disable iff (rst)
        (tx_arm_q && post_any && (status_next[C_TXLOW] && mask_next[C_TXLOW]) && !tx_full_evt)
        |=> !tx_arm_q); // R6

endmodule

// File: rtl/wmic_delay_timer.sv
module wmic_delay_timer
    import wmic_pkg::*;
#(
    parameter int DELAY_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  deliver_t           dlv,
    input  logic [DELAY_W-1:0] delay_q,
    input  logic               pending_any,
    output logic               irq_q
);

    logic               run_q, run_n, irq_n;
    logic [DELAY_W-1:0] cnt_q, cnt_n;
    logic               fire_now;

    assign fire_now = dlv.any && (dlv.urgent || delay_q == '0);

    always_comb begin
        irq_n = irq_q;
        run_n = run_q;
        cnt_n = cnt_q;
        if (run_q) begin
            if (cnt_q == DELAY_W'(1)) begin
                irq_n = 1'b1;
                run_n = 1'b0;
            end else begin
                cnt_n = cnt_q - DELAY_W'(1);
            end
        end
        if (fire_now) begin
            irq_n = 1'b1;
            run_n = 1'b0;
        end else if (dlv.any && !run_q && !irq_q) begin
            run_n = 1'b1;
            cnt_n = delay_q;
        end
        if (!pending_any) begin
            irq_n = 1'b0;
            run_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
            run_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            irq_q <= irq_n;
            run_q <= run_n;
            cnt_q <= cnt_n;
        end
    end

    AST_URGENT_NOW: assert property (@(posedge clk) disable iff (rst)
        (dlv.any && dlv.urgent && pending_any) |=> irq_q); // R7

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (run_q && cnt_q != DELAY_W'(1) && pending_any && !fire_now)
        |=> (run_q && (cnt_q + DELAY_W'(1)) == $past(cnt_q))); // R8

    AST_ZERO_DELAY: assert property (@(posedge clk) disable iff (rst)
        (dlv.any && delay_q == '0 && pending_any) |=> irq_q); // R11

endmodule

// File: rtl/wm_irq_ctrl.sv
module wm_irq_ctrl
    import wmic_pkg::*;
#(
    parameter int     DATA_W      = 16,
    parameter int     DELAY_W     = 16,
    parameter int     RESET_DELAY = 16,
    parameter cause_t NODELAY_SET = cause_t'(1 << C_SOFT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        cause_i,
    input  logic              rx_empty_i,
    input  logic              tx_full_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [1:0]        reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);

    logic               dev_rst;
    cause_t             status_q, mask_q, status_next, mask_next;
    logic [DELAY_W-1:0] delay_q;
    logic               post_any;
    deliver_t           dlv;

    // command reset acts like the external reset on the same edge
    assign dev_rst = rst || (reg_wr_i && reg_addr_i == RA_CMD && reg_wdata_i[CMD_RESET_BIT]);

    wmic_cause_regs #(
        .DATA_W      (DATA_W),
        .DELAY_W     (DELAY_W),
        .RESET_DELAY (RESET_DELAY)
    ) u_regs (
        .clk         (clk),
        .rst         (dev_rst),
        .wr          (reg_wr_i),
        .rd          (reg_rd_i),
        .addr        (reg_addr_i),
        .wdata       (reg_wdata_i),
        .cause_in    (cause_i),
        .status_q    (status_q),
        .mask_q      (mask_q),
        .delay_q     (delay_q),
        .status_next (status_next),
        .mask_next   (mask_next),
        .post_any    (post_any),
        .rdata       (reg_rdata_o)
    );

    wmic_wm_gate #(
        .NODELAY_SET (NODELAY_SET)
    ) u_gate (
        .clk          (clk),
        .rst          (dev_rst),
        .status_next  (status_next),
        .mask_next    (mask_next),
        .post_any     (post_any),
        .rx_empty_evt (rx_empty_i),
        .tx_full_evt  (tx_full_i),
        .dlv          (dlv)
    );

    wmic_delay_timer #(
        .DELAY_W (DELAY_W)
    ) u_timer (
        .clk         (clk),
        .rst         (dev_rst),
        .dlv         (dlv),
        .delay_q     (delay_q),
        .pending_any ((status_next & mask_next) != '0),
        .irq_q       (irq_o)
    );

    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (dev_rst)
        irq_o |-> ((status_q & mask_q) != '0)); // R9

endmodule

// File: tb/wm_irq_ctrl_bench.sv
module wm_irq_ctrl_bench;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    cause_i = '0;
    logic          rx_empty_i = 1'b0;
    logic          tx_full_i = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          irq_o;

    always #10 clk = ~clk;   // 50 MHz

    wm_irq_ctrl u_wm_irq_ctrl (
        .clk         (clk),
        .rst         (rst),
        .cause_i     (cause_i),
        .rx_empty_i  (rx_empty_i),
        .tx_full_i   (tx_full_i),
        .reg_wr_i    (reg_wr),
        .reg_rd_i    (reg_rd),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .irq_o       (irq_o)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string req_tag = "R4";

    // behavioural reference model
    int m_status, m_mask, m_delay, m_cnt;
    bit m_rx, m_tx, m_irq, m_run;
    int posts, ns, nm, eff;
    bit old_run, old_irq;

    always @(posedge clk) begin
        if (rst || (reg_wr && reg_addr == 2 && reg_wdata[1])) begin
            m_status = 0; m_mask = 15; m_delay = 16; m_cnt = 0;
            m_rx = 0; m_tx = 0; m_irq = 0; m_run = 0;
        end else begin
            posts = cause_i;
            if (reg_wr && reg_addr == 2 && reg_wdata[0]) posts = posts | 1;
            ns = m_status;
            if (reg_rd && reg_addr == 0) ns = 0;
            if (reg_wr && reg_addr == 0) ns = ns & ~int'(reg_wdata[7:0]);
            ns = (ns | posts) & 255;
            nm = (reg_wr && reg_addr == 1) ? int'(reg_wdata[7:0]) : m_mask;
            old_run = m_run;
            old_irq = m_irq;
            if (m_run) begin
                if (m_cnt == 1) begin m_irq = 1; m_run = 0; end
                else m_cnt = m_cnt - 1;
            end
            if (posts != 0) begin
                eff = ns & nm;
                if (!m_rx) eff = eff & ~2;
                if (!m_tx) eff = eff & ~8;
                if ((eff & 2) != 0) m_rx = 0;
                if ((eff & 8) != 0) m_tx = 0;
                if (eff != 0) begin
                    if ((eff & 1) != 0 || m_delay == 0) begin m_irq = 1; m_run = 0; end
                    else if (!old_run && !old_irq) begin m_run = 1; m_cnt = m_delay; end
                end
            end
            if (rx_empty_i) m_rx = 1;
            if (tx_full_i)  m_tx = 1;
            if ((ns & nm) == 0) begin m_irq = 0; m_run = 0; end
            if (reg_wr && reg_addr == 3) m_delay = reg_wdata;
            m_status = ns;
            m_mask   = nm;
        end
    end

    // compare the interrupt line against the model on every clock
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (irq_o !== m_irq) begin
                fails++;
                $display("FAIL %s irq_o actual=%0b expected=%0b at %0t", req_tag, irq_o, m_irq, $time);
            end
        end
    end

    task automatic clear_in();
        cause_i = '0; rx_empty_i = 0; tx_full_i = 0;
        reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(negedge clk); #5; clear_in(); end
    endtask

    task automatic post(input logic [7:0] c);
        @(negedge clk); #5; clear_in(); cause_i = c;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk); #5; clear_in(); reg_wr = 1; reg_addr = a; reg_wdata = d;
    endtask

    task automatic pulse_rx();
        @(negedge clk); #5; clear_in(); rx_empty_i = 1;
    endtask

    task automatic pulse_tx();
        @(negedge clk); #5; clear_in(); tx_full_i = 1;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [7:0] c,
                          input logic [DW-1:0] exp, input string tag);
        @(negedge clk); #5; clear_in(); reg_rd = 1; reg_addr = a; cause_i = c;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            fails++;
            $display("FAIL %s rdata addr=%0d actual=%h expected=%h", tag, a, reg_rdata, exp);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired, run hung");
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        clear_in();
        repeat (3) @(posedge clk);
        @(negedge clk); #5; rst = 0;

        // R4 reset state
        req_tag = "R4";
        rd_chk(2'd1, 8'h00, 16'h000F, "R4");
        rd_chk(2'd0, 8'h00, 16'h0000, "R4");
        rd_chk(2'd3, 8'h00, 16'd16,   "R4");

        // R8 delayed delivery, second post does not restart countdown
        req_tag = "R8";
        wr_reg(2'd3, 16'd4);
        post(8'h04);
        idle(2);
        post(8'h04);
        idle(6);
        req_tag = "R1";
        rd_chk(2'd0, 8'h00, 16'h0004, "R1");
        req_tag = "R9";
        idle(3);

        // R10 soft command, R7 immediate
        req_tag = "R7";
        wr_reg(2'd2, 16'h0001);
        idle(2);
        rd_chk(2'd0, 8'h00, 16'h0001, "R10");
        idle(2);

        // R3 clear-by-write of exact bits
        req_tag = "R3";
        post(8'h44);
        wr_reg(2'd0, 16'h0005);
        idle(6);
        rd_chk(2'd0, 8'h00, 16'h0040, "R3");
        idle(2);

        // R5 receive watermark one-shot
        req_tag = "R5";
        post(8'h02);
        idle(8);
        rd_chk(2'd0, 8'h00, 16'h0002, "R5");
        pulse_rx();
        post(8'h02);
        idle(6);
        rd_chk(2'd0, 8'h00, 16'h0002, "R5");
        idle(2);
        post(8'h02);
        idle(8);
        rd_chk(2'd0, 8'h00, 16'h0002, "R5");
        idle(2);

        // R6 transmit watermark one-shot
        req_tag = "R6";
        post(8'h08);
        idle(8);
        rd_chk(2'd0, 8'h00, 16'h0008, "R6");
        pulse_tx();
        post(8'h08);
        idle(6);
        rd_chk(2'd0, 8'h00, 16'h0008, "R6");
        idle(2);
        post(8'h08);
        idle(8);
        rd_chk(2'd0, 8'h00, 16'h0008, "R6");
        idle(2);

        // R11 zero delay
        req_tag = "R11";
        wr_reg(2'd3, 16'd0);
        post(8'h04);
        idle(2);
        rd_chk(2'd0, 8'h00, 16'h0004, "R11");
        idle(2);

        // R8 one-cycle delay boundary
        req_tag = "R8";
        wr_reg(2'd3, 16'd1);
        post(8'h04);
        idle(3);
        rd_chk(2'd0, 8'h00, 16'h0004, "R8");
        idle(2);

        // R9 mask write drops the line
        req_tag = "R9";
        wr_reg(2'd3, 16'd3);
        post(8'h04);
        idle(5);
        wr_reg(2'd1, 16'h0000);
        idle(3);
        rd_chk(2'd1, 8'h00, 16'h0000, "R9");
        rd_chk(2'd0, 8'h00, 16'h0004, "R9");
        idle(2);

        // R10 command reset restores defaults
        req_tag = "R10";
        wr_reg(2'd1, 16'h003C);
        wr_reg(2'd3, 16'd7);
        post(8'h10);
        wr_reg(2'd2, 16'h0003);
        idle(2);
        rd_chk(2'd1, 8'h00, 16'h000F, "R10");
        rd_chk(2'd3, 8'h00, 16'd16,   "R10");
        rd_chk(2'd0, 8'h00, 16'h0000, "R10");

        // R2 cause posted during status read survives
        req_tag = "R2";
        rd_chk(2'd0, 8'h04, 16'h0000, "R2");
        rd_chk(2'd0, 8'h00, 16'h0004, "R2");
        idle(20);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule